// File: doc/BRIEF.md
# Three-Phase Bridge Gate-Drive Sequencer

This block is the synchronous control logic behind the six gate enables of a three-phase half-bridge. Each phase takes an active-high low-side request and an active-low high-side request. It resolves them with low-side priority, and it holds back every turn-on by a programmable number of clock cycles. Turn-offs are never delayed, so the two switches of a phase are never on together. Setting the dead-time count to zero selects a bypass mode. In bypass the outputs simply follow the inputs, and both switches of a phase may be driven on at once.

A disable input or an undervoltage flag forces all six enables low. When both clear, the block runs a start-up sequence. First every low side is driven on for a programmed number of cycles to charge the bootstrap capacitors. The high sides stay blocked until a second, longer programmed count has passed since the release. After that, normal control resumes. Every control input passes through a two-flop synchronizer. The synchronizer resets to all ones, so the block comes out of reset disabled.

Top module: `bridge_gate_seq`

## Requirements
- R1: While rst_ni is low, all six outputs are 0. After reset the block stays in the disabled state, with all outputs 0, for as long as dis_i is 1.
- R2: The high-side request hi_n_i[k] (bit k is phase k) is active low. When lo_i[k]=0 and hi_n_i[k]=0 in normal running, hi_o[k] goes to 1. When hi_n_i[k]=1, hi_o[k] goes to 0.
- R3: When dead_cycles_i is nonzero and lo_i[k]=1, lo_o[k] turns on and hi_o[k] is forced to 0, whatever hi_n_i[k] is.
- R4: When dead_cycles_i=D is nonzero, an output turns off 3 cycles after its input change and turns on D cycles later than that. lo_o[k] and hi_o[k] are never 1 together.
- R5: With hi_n_i held at 0, toggling lo_i[k] alone alternates the phase between its low and high switch, with a D-cycle all-off gap. The other phases do not change.
- R6: With dead_cycles_i=0 (bypass), lo_o follows lo_i and hi_o follows ~hi_n_i with no priority, so both may be 1 together.
- R7: When dis_i is 1, all six outputs are 0 starting 3 cycles after dis_i rises.
- R8: When uv_i is 1, the outputs behave as in R7.
- R9: When dis_i and uv_i are both 0 again, all lo_o bits are 1 from the 3rd edge through the (refresh_cycles_i+2)th edge after the release edge, whatever lo_i and dead_cycles_i are. This is refresh_cycles_i cycles.
- R10: After release, hi_o stays 0 until hs_hold_cycles_i cycles (hs_hold_cycles_i > refresh_cycles_i) have passed. A pending high-side request then turns on at edge hs_hold_cycles_i+3+D after the release edge.
- R11: In bypass mode, an input change reaches the outputs at the third clock edge. The first two edges belong to the synchronizer and the third to the output register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| dead_cycles_i | input | DT_W | Dead-time count in cycles; 0 selects bypass |
| refresh_cycles_i | input | CNT_W | Low-side refresh length in cycles |
| hs_hold_cycles_i | input | CNT_W | Cycles from release until high sides are allowed |
| dis_i | input | 1 | Disable, active high |
| uv_i | input | 1 | Undervoltage flag, active high |
| lo_i | input | NUM_PH | Low-side requests, active high |
| hi_n_i | input | NUM_PH | High-side requests, active low |
| lo_o | output | NUM_PH | Low-side gate enables |
| hi_o | output | NUM_PH | High-side gate enables |

## Verification
The hardest part to reach from the ports is the timing after a release. The refresh window, the high-side hold and the dead time all stack on top of the synchronizer latency, and each boundary is visible on only one edge. The bench drives disable and undervoltage pulses and then samples the outputs just before and just after each computed edge. It does this once with a dead time and once in bypass. The dead-time gap is reached by switching one phase between its low and high switch while the others hold their high sides on. This shows that the gap is exact and that it stays local to that phase.

// File: rtl/bridge_seq_pkg.sv
package bridge_seq_pkg;
  typedef enum logic [1:0] {
    ST_OFF     = 2'd0,
    ST_REFRESH = 2'd1,
    ST_WAIT    = 2'd2,
    ST_RUN     = 2'd3
  } seq_state_e;
endpackage

// File: rtl/bridge_in_sync.sv
module bridge_in_sync #(
  parameter int unsigned WIDTH = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [WIDTH-1:0] s1_q, s2_q;

  // reset to ones: an unset input reads as disabled / off
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_q <= '1;
      s2_q <= '1;
    end else begin
      s1_q <= d_i;
      s2_q <= s1_q;
    end
  end

  assign q_o = s2_q;
endmodule

// File: rtl/bridge_startup_seq.sv
module bridge_startup_seq
  import bridge_seq_pkg::*;
#(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             kill_i,
  input  logic [CNT_W-1:0] refresh_len_i,
  input  logic [CNT_W-1:0] hold_len_i,
  output seq_state_e       state_o
);
  seq_state_e     st_q;
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W:0]   cnt_inc;

  assign cnt_inc = {1'b0, cnt_q} + 1'b1;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q  <= ST_OFF;
      cnt_q <= '0;
    end else if (kill_i) begin
      st_q  <= ST_OFF;
      cnt_q <= '0;
    end else begin
      unique case (st_q)
        ST_OFF: begin
          st_q  <= ST_REFRESH;
          cnt_q <= '0;
        end
        ST_REFRESH: begin
          cnt_q <= cnt_inc[CNT_W-1:0];
          if (cnt_inc >= {1'b0, refresh_len_i}) st_q <= ST_WAIT;
        end
        ST_WAIT: begin
          cnt_q <= cnt_inc[CNT_W-1:0];
          if (cnt_inc >= {1'b0, hold_len_i}) st_q <= ST_RUN;
        end
        default: cnt_q <= cnt_q;
      endcase
    end
  end

  assign state_o = st_q;
endmodule

// File: rtl/bridge_phase_ctrl.sv
module bridge_phase_ctrl #(
  parameter int unsigned DT_W = 8
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [DT_W-1:0] dead_i,
  input  logic            force_off_i,
  input  logic            refresh_i,
  input  logic            hi_block_i,
  input  logic            lo_req_i,
  input  logic            hi_req_i,
  output logic            lo_o,
  output logic            hi_o
);
  localparam logic [DT_W-1:0] AGE_MAX = '1;

  logic            bypass;
  logic            want_lo, want_hi;
  logic [1:0]      tgt_q;
  logic [DT_W-1:0] age_q;
  logic            settled;
  logic            lo_q, hi_q;

  assign bypass = (dead_i == '0);

  always_comb begin
    if (force_off_i) begin
      want_lo = 1'b0;
      want_hi = 1'b0;
    end else if (refresh_i) begin
      want_lo = 1'b1;
      want_hi = 1'b0;
    end else begin
      want_lo = lo_req_i;
      want_hi = hi_req_i & ~hi_block_i & (bypass | ~lo_req_i);
    end
  end

  // target unchanged long enough to cover the dead time
  assign settled = ({want_lo, want_hi} == tgt_q) && (age_q >= dead_i - 1'b1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tgt_q <= '0;
      age_q <= '0;
      lo_q  <= 1'b0;
      hi_q  <= 1'b0;
    end else begin
      tgt_q <= {want_lo, want_hi};
      if ({want_lo, want_hi} != tgt_q) age_q <= '0;
      else if (age_q != AGE_MAX)       age_q <= age_q + 1'b1;
      // refresh always follows all-off, so no gap is needed there
      if (bypass || refresh_i) begin
        lo_q <= want_lo;
        hi_q <= want_hi;
      end else begin
        lo_q <= want_lo & (lo_q | settled);
        hi_q <= want_hi & (hi_q | settled);
      end
    end
  end

  assign lo_o = lo_q;
  assign hi_o = hi_q;
endmodule

// File: rtl/bridge_gate_seq.sv
module bridge_gate_seq
  import bridge_seq_pkg::*;
#(
  parameter int unsigned NUM_PH = 3,
  parameter int unsigned DT_W   = 8,
  parameter int unsigned CNT_W  = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [DT_W-1:0]   dead_cycles_i,
  input  logic [CNT_W-1:0]  refresh_cycles_i,
  input  logic [CNT_W-1:0]  hs_hold_cycles_i,
  input  logic              dis_i,
  input  logic              uv_i,
  input  logic [NUM_PH-1:0] lo_i,
  input  logic [NUM_PH-1:0] hi_n_i,
  output logic [NUM_PH-1:0] lo_o,
  output logic [NUM_PH-1:0] hi_o
);
  localparam int unsigned SYNC_W = 2 * NUM_PH + 2;

  logic [SYNC_W-1:0] sync_q;
  logic              dis_s, uv_s, kill_s;
  logic [NUM_PH-1:0] lo_s, hi_n_s;
  seq_state_e        st;
  logic              force_off, refresh, hi_block;

  bridge_in_sync #(.WIDTH(SYNC_W)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   ({dis_i, uv_i, lo_i, hi_n_i}),
    .q_o   (sync_q)
  );

  assign {dis_s, uv_s, lo_s, hi_n_s} = sync_q;
  assign kill_s = dis_s | uv_s;

  bridge_startup_seq #(.CNT_W(CNT_W)) u_seq (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .kill_i       (kill_s),
    .refresh_len_i(refresh_cycles_i),
    .hold_len_i   (hs_hold_cycles_i),
    .state_o      (st)
  );

  assign force_off = kill_s | (st == ST_OFF);
  assign refresh   = (st == ST_REFRESH);
  assign hi_block  = (st != ST_RUN);

  for (genvar k = 0; k < NUM_PH; k++) begin : g_ph
    bridge_phase_ctrl #(.DT_W(DT_W)) u_ph (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .dead_i     (dead_cycles_i),
      .force_off_i(force_off),
      .refresh_i  (refresh),
      .hi_block_i (hi_block),
      .lo_req_i   (lo_s[k]),
      .hi_req_i   (~hi_n_s[k]),
      .lo_o       (lo_o[k]),
      .hi_o       (hi_o[k])
    );
  end
endmodule

// File: rtl/bridge_gate_seq_chk.sv
module bridge_gate_seq_chk
  import bridge_seq_pkg::*;
#(
  parameter int unsigned NUM_PH = 3,
  parameter int unsigned DT_W   = 8
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [DT_W-1:0]   dead_cycles_i,
  input logic              kill_s,
  input seq_state_e        st,
  input logic [NUM_PH-1:0] lo_o,
  input logic [NUM_PH-1:0] hi_o
);
  always @(posedge clk_i) begin
    if (!rst_ni) begin
      p_reset_off_r1: assert (lo_o == '0 && hi_o == '0)
        else $error("R1 outputs active in reset");
    end
  end

  p_no_overlap_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dead_cycles_i != '0 && $past(dead_cycles_i) != '0) |-> ((lo_o & hi_o) == '0))
    else $error("R4 both switches on");

  p_kill_off_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    kill_s |=> (lo_o == '0 && hi_o == '0))
    else $error("R7/R8 outputs not forced off");

  p_refresh_lo_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st == ST_REFRESH && !kill_s) |=> (lo_o == '1 && hi_o == '0))
    else $error("R9 refresh pulse missing");

  p_hi_blocked_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st != ST_RUN) |=> (hi_o == '0))
    else $error("R10 high side before hold");
endmodule

bind bridge_gate_seq bridge_gate_seq_chk #(.NUM_PH(NUM_PH), .DT_W(DT_W)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .dead_cycles_i(dead_cycles_i),
  .kill_s       (kill_s),
  .st           (st),
  .lo_o         (lo_o),
  .hi_o         (hi_o)
);

// File: tb/bridge_gate_seq_tb_top.sv
`timescale 1ns/1ps
module bridge_gate_seq_tb_top;
  localparam int NUM_PH = 3;
  localparam int DT_W   = 8;
  localparam int CNT_W  = 16;
  localparam int DT     = 4;
  localparam int RF     = 10;
  localparam int HOLD   = 25;

  logic              clk_i = 1'b0;
  logic              rst_ni;
  logic [DT_W-1:0]   dead_cycles_i;
  logic [CNT_W-1:0]  refresh_cycles_i;
  logic [CNT_W-1:0]  hs_hold_cycles_i;
  logic              dis_i, uv_i;
  logic [NUM_PH-1:0] lo_i, hi_n_i;
  logic [NUM_PH-1:0] lo_o, hi_o;

  int n_run  = 0;
  int n_fail = 0;
  bit done   = 0;

  always #5 clk_i = ~clk_i;

  bridge_gate_seq #(.NUM_PH(NUM_PH), .DT_W(DT_W), .CNT_W(CNT_W)) dut_i (
    .clk_i, .rst_ni, .dead_cycles_i, .refresh_cycles_i, .hs_hold_cycles_i,
    .dis_i, .uv_i, .lo_i, .hi_n_i, .lo_o, .hi_o
  );

  task automatic wait_edges(input int n);
    repeat (n) @(posedge clk_i);
    #1;
  endtask

  // compares {hi_o, lo_o}
  task automatic chk(input string tag, input logic [5:0] exp);
    n_run++;
    if ({hi_o, lo_o} !== exp) begin
      n_fail++;
      $display("FAIL %s: {hi,lo} actual=%b expected=%b at %0t", tag, {hi_o, lo_o}, exp, $time);
    end
  endtask

  task automatic t_reset();
    rst_ni = 1'b0; dis_i = 1'b1; uv_i = 1'b0; lo_i = '0; hi_n_i = '1;
    dead_cycles_i = DT; refresh_cycles_i = RF; hs_hold_cycles_i = HOLD;
    wait_edges(3);
    chk("R1 in reset", 6'b000_000);
    @(negedge clk_i); rst_ni = 1'b1;
    lo_i = '1; hi_n_i = '0;
    wait_edges(8);
    chk("R1 disabled after reset", 6'b000_000);
  endtask

  // release kill with lo=0, hi_n=0 pending; d = active dead time
  task automatic t_release(input string tag, input int d, input bit use_uv);
    @(negedge clk_i);
    lo_i = '0; hi_n_i = '0;
    if (use_uv) uv_i = 1'b0; else dis_i = 1'b0;
    wait_edges(3);
    chk({tag, " R9 before refresh"}, 6'b000_000);
    wait_edges(1);
    chk({tag, " R9 refresh start"}, 6'b000_111);
    wait_edges(RF - 1);
    chk({tag, " R9 refresh last"}, 6'b000_111);
    wait_edges(1);
    chk({tag, " R9 refresh end"}, 6'b000_000);
    wait_edges(HOLD - RF - 1 + d);
    chk({tag, " R10 hi still blocked"}, 6'b000_000);
    wait_edges(1);
    chk({tag, " R10 hi enabled"}, 6'b111_000);
  endtask

  task automatic t_dead_toggle();
    @(negedge clk_i); lo_i = 3'b001;
    wait_edges(3);
    chk("R3 R4 hi0 off at once", 6'b110_000);
    wait_edges(DT - 1);
    chk("R4 lo0 still waiting", 6'b110_000);
    wait_edges(1);
    chk("R3 lo0 on after dead", 6'b110_001);
    @(negedge clk_i); lo_i = 3'b000;
    wait_edges(3);
    chk("R5 lo0 off at once", 6'b110_000);
    wait_edges(DT - 1);
    chk("R5 gap before hi0", 6'b110_000);
    wait_edges(1);
    chk("R5 hi0 back on", 6'b111_000);
  endtask

  task automatic t_hi_release();
    @(negedge clk_i); hi_n_i = 3'b101;
    wait_edges(2);
    chk("R2 before sync", 6'b111_000);
    wait_edges(1);
    chk("R2 hi_n high turns off", 6'b010_000);
    @(negedge clk_i); hi_n_i = 3'b111;
    wait_edges(3);
    chk("R2 all high-side off", 6'b000_000);
  endtask

  task automatic t_bypass();
    @(negedge clk_i); dead_cycles_i = '0;
    wait_edges(2);
    @(negedge clk_i); lo_i = 3'b111; hi_n_i = 3'b000;
    wait_edges(2);
    chk("R11 bypass latency", 6'b000_000);
    wait_edges(1);
    chk("R6 bypass both on", 6'b111_111);
    @(negedge clk_i); lo_i = 3'b010; hi_n_i = 3'b110;
    wait_edges(3);
    chk("R6 R11 bypass follow", 6'b001_010);
    @(negedge clk_i); lo_i = '0; hi_n_i = '1;
    wait_edges(3);
    chk("R6 bypass all off", 6'b000_000);
  endtask

  task automatic t_kill(input string tag, input bit use_uv);
    @(negedge clk_i); lo_i = 3'b100; hi_n_i = 3'b100;
    wait_edges(6 + DT);
    chk({tag, " setup"}, 6'b011_100);
    @(negedge clk_i);
    if (use_uv) uv_i = 1'b1; else dis_i = 1'b1;
    wait_edges(2);
    chk({tag, " before sync"}, 6'b011_100);
    wait_edges(1);
    chk({tag, " forced off"}, 6'b000_000);
    @(negedge clk_i); lo_i = '1; hi_n_i = '0;
    wait_edges(10);
    chk({tag, " stays off"}, 6'b000_000);
  endtask

  initial begin
    t_reset();
    t_release("rel1", DT, 1'b0);
    t_dead_toggle();
    t_hi_release();
    t_bypass();
    @(negedge clk_i); dead_cycles_i = DT;
    t_kill("R7 dis", 1'b0);
    t_release("rel2", DT, 1'b0);
    t_kill("R8 uv", 1'b1);
    @(negedge clk_i); dead_cycles_i = '0;
    t_release("rel3 bypass", 0, 1'b1);
    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    #200000;
    if (!done) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule